// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It samples the line once per tick of an external clock that runs at sixteen times the bit rate. It finds the start of each frame, shifts in the data bits with the least significant bit first, and moves each finished character into a holding buffer. The buffer keeps that character while the next frame is being shifted in, so software has a whole frame time to collect it.

The frame format is set by four static configuration inputs. They must match the far-end transmitter and must not change while a frame is in progress. A character has 7 or 8 bits. A parity bit, even or odd, is optional, and each frame ends with one or two stop bits. At the sample point of the first stop bit the buffer is loaded, and the buffer-full flag, the overrun, parity and framing error flags and a one-cycle interrupt request all update in the same clock. A read strobe clears the full flag. A clear strobe clears the three error flags, which stay set until then.

Top module: `uart_rx_dbuf`

## Requirements
- R1: After reset, `rx_data` is 0, and `rbf`, `ovr_err`, `par_err`, `frm_err` and `rx_irq` are all 0.
- R2: An 8-bit frame with no parity and one stop bit is received. The character is taken least significant bit first, appears on `rx_data`, and `rbf` goes to 1.
- R3: With `cfg_len8`=0, seven data bits are received, they appear on `rx_data[6:0]`, and `rx_data[7]` is 0.
- R4: A low pulse on `rxd` that has ended before the middle of the start bit is rejected. No character is loaded and `rbf` stays 0.
- R5: With `cfg_par_en`=1, the bit after the data is parity. `par_err` is set when the count of ones in the data and parity bits is odd with `cfg_par_odd`=0, or even with `cfg_par_odd`=1. It is not set when the count matches the configured parity.
- R6: A first stop bit sampled low sets `frm_err`. The character is still loaded and `rbf` still goes to 1.
- R7: When a character completes while `rbf` is 1 and no read strobe is present, `ovr_err` is set and the buffer is overwritten with the new character.
- R8: A one-cycle `rd_stb` clears `rbf` and leaves `rx_data` unchanged.
- R9: `rx_irq` is high for exactly one clock per received character, in the same cycle in which `rbf` first shows the new load.
- R10: With `cfg_stop2`=1, only the first stop bit is checked. A low second stop bit does not set `frm_err`, and the receiver then accepts the next frame.
- R11: Error flags are sticky across later good frames. A one-cycle `err_clr` clears all three flags.
- R12: A read strobe issued while the next frame is still being shifted in prevents an overrun for that next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rxd | input | 1 | Serial line input, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop2 | input | 1 | 1: two stop bits |
| rd_stb | input | 1 | Buffer read strobe, clears rbf |
| err_clr | input | 1 | Clears the three error flags |
| rx_data | output | 8 | Receive buffer contents |
| rbf | output | 1 | Receive buffer full |
| ovr_err | output | 1 | Overrun error flag |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
The case that is hardest to reach from the ports is the read that races the next character. The buffer must be emptied while the shift register is already partway through the following frame, so that the load at the first stop bit finds the buffer empty. The bench starts sending the second frame and, in a parallel thread, issues the read strobe two bit times into it. It then checks that the new character arrived and that no overrun was flagged. The overrun case is the mirror of this: two frames are sent with no read at all. The stimulus for the two-stop-bit case holds the second stop bit low on purpose, to show that this bit is never judged.

// File: rtl/uart_rx_pkg.sv
// Package: shared types and constants for the serial receiver.
// Assumes: nothing; pure declarations.
package uart_rx_pkg;
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_STOP2
    } rx_state_t;

    localparam int RX_OSR = 16;
endpackage

// File: rtl/uart_rx_sync.sv
// Module: multi-stage synchronizer that brings the asynchronous line into
// the clock domain.
// Assumes: STAGES >= 2; the line idles high, so the stages reset to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Module: frame engine. It hunts for a falling edge, confirms the start bit
// at mid-bit, samples data, parity and the first stop bit at mid-bit, and
// pulses done together with the character and its error status.
// Assumes: tick pulses OSR times per bit; the cfg inputs are stable during a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = RX_OSR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          len_full,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          stop2,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          par_bad,
    output logic          frm_bad
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bidx;
    logic          prev;
    logic          pbit;
    logic [DW-1:0] shreg;
    logic          last_bit;

    // Index of the final data bit for the configured character length.
    assign last_bit = (bidx == (len_full ? IW'(DW-1) : IW'(DW-2)));

    // Frame sequencing, bit sampling and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            prev    <= 1'b1;
            pbit    <= 1'b0;
            shreg   <= '0;
            done    <= 1'b0;
            data    <= '0;
            par_bad <= 1'b0;
            frm_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                prev <= rxd;
                cnt  <= cnt + 1'b1;
                case (state)
                    RX_IDLE: begin
                        cnt <= '0;
                        if (prev && !rxd) begin
                            state <= RX_START;
                            shreg <= '0;
                            bidx  <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == MID) begin
                            cnt   <= '0;
                            state <= rxd ? RX_IDLE : RX_DATA;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            shreg[bidx] <= rxd;
                            bidx        <= bidx + 1'b1;
                            if (last_bit) state <= par_en ? RX_PAR : RX_STOP;
                        end
                    end
                    RX_PAR: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            pbit  <= rxd;
                            state <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            done    <= 1'b1;
                            data    <= shreg;
                            frm_bad <= !rxd;
                            par_bad <= par_en && ((^shreg) ^ pbit ^ par_odd);
                            state   <= stop2 ? RX_STOP2 : RX_IDLE;
                        end
                    end
                    RX_STOP2: begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= RX_IDLE;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R4: a line found high at the mid-start check drops the frame.
    a_r4_glitch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && tick && cnt == MID && rxd) |=> state == RX_IDLE);

    // R6: completion comes only from the first stop bit.
    a_r6_done_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state) == RX_STOP);

    // R10: the second stop bit never produces a completion.
    a_r10_stop2_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STOP2) |=> !done);
endmodule

// File: rtl/uart_rx_buf.sv
// Module: receive buffer and status flags. It loads on done, sets the full
// flag, accumulates the sticky error flags and pulses the interrupt.
// Assumes: load is a one-cycle pulse; when load and a strobe coincide, load wins.
module uart_rx_buf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          par_bad,
    input  logic          frm_bad,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          ovr,
    output logic          perr,
    output logic          ferr,
    output logic          irq
);
    logic ovr_base, perr_base, ferr_base;

    // Flag values after an optional clear, before any new load.
    assign ovr_base  = clr ? 1'b0 : ovr;
    assign perr_base = clr ? 1'b0 : perr;
    assign ferr_base = clr ? 1'b0 : ferr;

    // Buffer load, full flag, sticky errors and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= load;
            if (load) begin
                dout <= din;
                full <= 1'b1;
                ovr  <= ovr_base | (full & ~rd);
                perr <= perr_base | par_bad;
                ferr <= ferr_base | frm_bad;
            end else begin
                if (rd) full <= 1'b0;
                ovr  <= ovr_base;
                perr <= perr_base;
                ferr <= ferr_base;
            end
        end
    end

    // R2: a completed character marks the buffer full.
    a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
    // R8: a read strobe empties the buffer and keeps the data.
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !load) |=> (!full && $stable(dout)));
    // R7: a load into a full, unread buffer raises overrun.
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (load && full && !rd) |=> ovr);
    // R9: the interrupt is seen only together with a full buffer.
    a_r9_irq_full: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> full);
    // R11: a clear with no load empties all error flags.
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !load) |=> (!ovr && !perr && !ferr));
endmodule

// File: rtl/uart_rx_dbuf.sv
// Module: top of the double-buffered serial receiver. It chains the
// synchronizer, the frame engine and the receive buffer.
// Assumes: tick16 comes from an external rate generator at 16x the bit rate.
module uart_rx_dbuf
    import uart_rx_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic          cfg_len8,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_stop2,
    input  logic          rd_stb,
    input  logic          err_clr,
    output logic [DW-1:0] rx_data,
    output logic          rbf,
    output logic          ovr_err,
    output logic          par_err,
    output logic          frm_err,
    output logic          rx_irq
);
    logic          rxd_s;
    logic          f_done;
    logic [DW-1:0] f_data;
    logic          f_par_bad;
    logic          f_frm_bad;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    uart_rx_frame #(.DW(DW), .OSR(RX_OSR)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .rxd     (rxd_s),
        .len_full(cfg_len8),
        .par_en  (cfg_par_en),
        .par_odd (cfg_par_odd),
        .stop2   (cfg_stop2),
        .done    (f_done),
        .data    (f_data),
        .par_bad (f_par_bad),
        .frm_bad (f_frm_bad)
    );

    uart_rx_buf #(.DW(DW)) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (f_done),
        .din    (f_data),
        .par_bad(f_par_bad),
        .frm_bad(f_frm_bad),
        .rd     (rd_stb),
        .clr    (err_clr),
        .dout   (rx_data),
        .full   (rbf),
        .ovr    (ovr_err),
        .perr   (par_err),
        .ferr   (frm_err),
        .irq    (rx_irq)
    );
endmodule

// File: tb/uart_rx_dbuf_tb.sv
module uart_rx_dbuf_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int BIT_CYC    = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
    logic       rd_stb = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rbf, ovr_err, par_err, frm_err, rx_irq;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    int irq_bad = 0;
    int tdiv = 0;

    uart_rx_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .rd_stb(rd_stb), .err_clr(err_clr),
        .rx_data(rx_data), .rbf(rbf), .ovr_err(ovr_err), .par_err(par_err),
        .frm_err(frm_err), .rx_irq(rx_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        tdiv   <= (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 0);
    end

    always @(negedge clk) begin
        if (rx_irq) irq_cnt++;
        if (rx_irq && !rbf) irq_bad++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v);
        rxd = v;
        repeat (BIT_CYC) @(negedge clk);
    endtask

    // Sends one frame with the current configuration; no trailing idle.
    task automatic send_frame(input logic [7:0] d, input bit flip_par,
                              input logic s1, input logic s2);
        int nb = cfg_len8 ? 8 : 7;
        logic p = cfg_par_odd ^ flip_par;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(d[i]);
            p ^= d[i];
        end
        if (cfg_par_en) drive_bit(p);
        drive_bit(s1);
        if (cfg_stop2) drive_bit(s2);
        rxd = 1'b1;
    endtask

    task automatic pulse_rd;
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic pulse_clr;
        @(negedge clk) err_clr = 1'b1;
        @(negedge clk) err_clr = 1'b0;
    endtask

    task automatic idle;
        drive_bit(1'b1);
    endtask

    task automatic t_reset;
        chk(rx_data == 8'h00 && !rbf && !rx_irq, "R1 data/rbf/irq", {rx_data, rbf, rx_irq}, 0);
        chk(!ovr_err && !par_err && !frm_err, "R1 flags", {ovr_err, par_err, frm_err}, 0);
    endtask

    task automatic t_basic;
        int c0 = irq_cnt;
        send_frame(8'hA5, 0, 1'b1, 1'b1); idle;
        chk(rbf && rx_data == 8'hA5, "R2 8N1 char", rx_data, 8'hA5);
        chk(irq_cnt == c0 + 1 && irq_bad == 0, "R9 single irq with rbf", irq_cnt - c0, 1);
        pulse_rd; @(negedge clk);
        chk(!rbf && rx_data == 8'hA5, "R8 read clears rbf keeps data", {rbf, rx_data}, 8'hA5);
    endtask

    task automatic t_seven;
        cfg_len8 = 1'b0;
        send_frame(8'hB3, 0, 1'b1, 1'b1); idle;
        chk(rbf && rx_data == 8'h33, "R3 7-bit char", rx_data, 8'h33);
        cfg_len8 = 1'b1;
        pulse_rd;
    endtask

    task automatic t_glitch;
        rxd = 1'b0; repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1; repeat (3 * BIT_CYC) @(negedge clk);
        chk(!rbf, "R4 glitch rejected", rbf, 0);
    endtask

    task automatic t_parity;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send_frame(8'h37, 0, 1'b1, 1'b1); idle;
        chk(rbf && !par_err, "R5 even parity good", par_err, 0);
        pulse_rd;
        send_frame(8'h37, 1, 1'b1, 1'b1); idle;
        chk(par_err && rx_data == 8'h37, "R5 even parity bad", par_err, 1);
        pulse_rd;
        send_frame(8'h01, 0, 1'b1, 1'b1); idle;
        chk(par_err, "R11 parity flag sticky", par_err, 1);
        pulse_clr; @(negedge clk);
        chk(!par_err && !ovr_err && !frm_err, "R11 clear", {ovr_err, par_err, frm_err}, 0);
        pulse_rd;
        cfg_par_odd = 1'b1;
        send_frame(8'h6C, 0, 1'b1, 1'b1); idle;
        chk(!par_err && rx_data == 8'h6C, "R5 odd parity good", par_err, 0);
        pulse_rd;
        send_frame(8'h6C, 1, 1'b1, 1'b1); idle;
        chk(par_err, "R5 odd parity bad", par_err, 1);
        pulse_rd; pulse_clr;
        cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    endtask

    task automatic t_frame;
        send_frame(8'h5A, 0, 1'b0, 1'b1); idle; idle;
        chk(frm_err && rbf && rx_data == 8'h5A, "R6 framing error still loads", {frm_err, rbf}, 3);
        pulse_rd; pulse_clr;
    endtask

    task automatic t_overrun;
        send_frame(8'h11, 0, 1'b1, 1'b1);
        send_frame(8'h22, 0, 1'b1, 1'b1); idle;
        chk(ovr_err && rbf && rx_data == 8'h22, "R7 overrun overwrites", {ovr_err, rx_data}, 9'h122);
        pulse_rd; pulse_clr;
    endtask

    task automatic t_stop2;
        cfg_stop2 = 1'b1;
        send_frame(8'hC4, 0, 1'b1, 1'b0); idle;
        chk(rbf && !frm_err && rx_data == 8'hC4, "R10 second stop ignored", frm_err, 0);
        pulse_rd;
        send_frame(8'h3E, 0, 1'b1, 1'b1); idle;
        chk(rbf && rx_data == 8'h3E && !ovr_err, "R10 next frame after stop2", rx_data, 8'h3E);
        pulse_rd;
        cfg_stop2 = 1'b0;
    endtask

    task automatic t_read_race;
        send_frame(8'h9D, 0, 1'b1, 1'b1);
        fork
            send_frame(8'h4B, 0, 1'b1, 1'b1);
            begin repeat (2 * BIT_CYC) @(negedge clk); pulse_rd; end
        join
        idle;
        chk(rbf && rx_data == 8'h4B && !ovr_err, "R12 read during next frame", {ovr_err, rx_data}, 8'h4B);
        pulse_rd;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        repeat (2 * BIT_CYC) @(negedge clk);
        t_reset;
        t_basic;
        t_seven;
        t_glitch;
        t_parity;
        t_frame;
        t_overrun;
        t_stop2;
        t_read_race;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule